// File: doc/BRIEF.md
# Nonvolatile option bit controller

This block keeps a small bank of persistent option bits and lets software change or inspect them through a command register. Each command word carries a protection key, an operation code and an argument. A word with a correct key and a known code starts a fixed programming delay. At the end of that delay the operation takes effect and the ready flag returns high. A word with a wrong key or an unknown code is dropped and latches an error flag. If ready interrupts are enabled, the interrupt line follows the ready flag.

A get command makes the option bits readable from a result register, 32 bits per read. The first read after a get returns bits 31..0, and every later read moves on by one word. Words past the implemented bits read as zero. Option bit 0 is a security lock. While it is set, the debug port and the parallel programming port are refused access. Ordinary processor reads are always granted. Software cannot remove the lock. Only a full erase performed while the external erase pin is high clears the bank. The bits are held in registers that model the persistent storage.

Register map, selected by `reg_addr`: 0 is the command register, 1 is the mode register, 2 is the status register and 3 is the result register.

Top module: `optbit_ctrl`

## Requirements
- R1: After reset, status reads 0x1 (bit 0 ready = 1, bit 1 error = 0), `irq` is 0, and the option bits equal `INIT` (default 0).
- R2: A command write has key = bits 31..24 = 0x5A, argument = bits 23..8 and code = bits 7..0, with 0x0B = set, 0x0C = clear and 0x0D = get. If the block is idle, an accepted write drops ready on the next cycle, and ready rises again exactly `PROG_CYCLES` clock edges after the write edge.
- R3: A command write with a key other than 0x5A, or with an unknown code, executes nothing, sets the status error bit (bit 1) and leaves ready at 1.
- R4: Set with an argument below `NBITS` makes that option bit 1. Clear with an argument between 1 and `NBITS`-1 makes that option bit 0.
- R5: Set or clear with an argument of `NBITS` or more changes no option bit.
- R6: Mode register bit 0 enables the interrupt: `irq` is 1 exactly when ready is 1 and that bit is 1.
- R7: The get command ignores its argument. Each read of the result register returns the next 32-bit word of the option bits, starting at bits 31..0, and words past the implemented bits read 0. A new get restarts the sequence at word 0.
- R8: A read of the status register clears the error bit. The read itself still returns the value the bit had before it was cleared.
- R9: While option bit 0 is 1, `dbg_grant` and `pp_grant` are 0. `cpu_grant` always equals `cpu_req`, also while a command is in progress.
- R10: A clear command for bit 0 leaves bit 0 set. A `full_erase` pulse while `erase_pin` is 1 clears all option bits and restores debug and programming grants. A `full_erase` pulse while `erase_pin` is 0 changes nothing.
- R11: A command write that arrives while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status clear, result advance) |
| reg_addr | input | 2 | Register select: 0 command, 1 mode, 2 status, 3 result |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Ready interrupt |
| erase_pin | input | 1 | External erase enable pin |
| full_erase | input | 1 | Full erase pulse |
| dbg_req | input | 1 | Debug port access request |
| dbg_grant | output | 1 | Debug port access grant |
| pp_req | input | 1 | Parallel programming port request |
| pp_grant | output | 1 | Parallel programming port grant |
| cpu_req | input | 1 | Processor flash read request |
| cpu_grant | output | 1 | Processor flash read grant |

## Verification
Commands are issued with a good key, with a bad key, with an unknown code, and with in-range, out-of-range and far out-of-range bit indices. The results tell apart a command that ran, one that was filtered, and one that corrupted other bits. The get command is tried with a zero argument and with a nonzero argument, and its readout is followed past the last implemented word and then restarted. This shows that the read pointer moves forward, saturates to zero data, and returns to word 0 on a new get. The lock is exercised four ways: a software clear, an erase pulse without the pin, an erase pulse with the pin, and a command sent while another is still busy. Each of these changes the grant outputs in a different way or leaves them alone.

// File: rtl/optbit_ctrl.sv
module optbit_ctrl #(
  parameter int NBITS = 4,
  parameter logic [NBITS-1:0] INIT = '0,
  parameter int PROG_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        erase_pin,
  input  logic        full_erase,
  input  logic        dbg_req,
  output logic        dbg_grant,
  input  logic        pp_req,
  output logic        pp_grant,
  input  logic        cpu_req,
  output logic        cpu_grant
);
  localparam int NW = (NBITS + 31) / 32;
  localparam int PADW = NW * 32;
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [7:0] KEY = 8'h5A;
  localparam logic [7:0] OP_SET = 8'h0B;
  localparam logic [7:0] OP_CLR = 8'h0C;
  localparam logic [7:0] OP_GET = 8'h0D;

  logic [NBITS-1:0] bits;
  logic [CW-1:0]    cnt;
  logic [7:0]       op;
  logic [15:0]      arg;
  logic [7:0]       ptr;
  logic             busy, ready, err, ie;

  wire cmd_wr  = reg_wr && reg_addr == 2'd0;
  wire code_ok = reg_wdata[7:0] == OP_SET || reg_wdata[7:0] == OP_CLR || reg_wdata[7:0] == OP_GET;
  wire good    = reg_wdata[31:24] == KEY && code_ok;
  wire done    = busy && cnt == CW'(1);
  wire erase   = erase_pin && full_erase;

  logic [PADW-1:0] padded;
  logic [31:0]     res_word;
  assign padded   = PADW'(bits);
  assign res_word = 32'(padded >> {ptr, 5'b0});

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = {31'b0, ie};
      2'd2:    reg_rdata = {30'b0, err, ready};
      2'd3:    reg_rdata = res_word;
      default: reg_rdata = '0;
    endcase
  end

  assign irq       = ready && ie;
  assign dbg_grant = dbg_req && !bits[0];
  assign pp_grant  = pp_req && !bits[0];
  assign cpu_grant = cpu_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits  <= INIT;
      cnt   <= '0;
      op    <= '0;
      arg   <= '0;
      ptr   <= '0;
      busy  <= 1'b0;
      ready <= 1'b1;
      err   <= 1'b0;
      ie    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd1) ie <= reg_wdata[0];
      if (reg_rd && reg_addr == 2'd2) err <= 1'b0;
      if (reg_rd && reg_addr == 2'd3 && ptr != 8'hFF) ptr <= ptr + 8'd1;
      if (done) begin
        busy  <= 1'b0;
        ready <= 1'b1;
        for (int i = 0; i < NBITS; i++) begin
          if (arg == 16'(i)) begin
            if (op == OP_SET) bits[i] <= 1'b1;
            else if (op == OP_CLR && i != 0) bits[i] <= 1'b0;
          end
        end
      end else if (busy) begin
        cnt <= cnt - CW'(1);
      end
      if (cmd_wr && !busy) begin
        if (good) begin
          busy  <= 1'b1;
          ready <= 1'b0;
          cnt   <= CW'(PROG_CYCLES);
          op    <= reg_wdata[7:0];
          arg   <= reg_wdata[23:8];
          if (reg_wdata[7:0] == OP_GET) ptr <= '0;
        end else begin
          err <= 1'b1;
        end
      end
      if (erase) bits <= '0;
    end
  end

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && good |=> !ready);
  assert_bad_cmd_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && !good |=> err && $stable(bits));
  assert_out_of_range_keeps_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && arg >= 16'(NBITS) && !erase |=> $stable(bits));
  assert_lock_only_by_erase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bits[0]) |-> $past(erase));
  assert_status_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 2'd2 && !cmd_wr |=> !err);
endmodule

// File: tb/optbit_ctrl_tb.sv
module optbit_ctrl_tb_top;
  localparam int P = 8;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, erase_pin = 0, full_erase = 0;
  logic dbg_req = 0, dbg_grant, pp_req = 0, pp_grant, cpu_req = 0, cpu_grant;
  int total = 0, bad = 0;
  logic [3:0] exp_bits = 4'h0;
  bit finished = 0;

  always #10 clk = ~clk;

  optbit_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .erase_pin(erase_pin), .full_erase(full_erase), .dbg_req(dbg_req), .dbg_grant(dbg_grant),
    .pp_req(pp_req), .pp_grant(pp_grant), .cpu_req(cpu_req), .cpu_grant(cpu_grant));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    repeat (P) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] code, logic [15:0] arg, logic [7:0] key = 8'h5A);
    wr_reg(2'd0, {key, arg, code});
    wait_done();
  endtask

  task automatic get_bits(string req, logic [15:0] arg = 16'h0);
    logic [31:0] w;
    cmd(8'h0D, arg);
    rd_reg(2'd3, w);
    check(req, w, {28'b0, exp_bits});
  endtask

  task automatic t_reset();
    logic [31:0] w;
    peek(2'd2, w); check("R1 status", w, 32'h1);
    check("R1 irq", irq, 0);
    get_bits("R1 init bits");
  endtask

  task automatic t_set_timing();
    logic [31:0] w;
    wr_reg(2'd0, {8'h5A, 16'd2, 8'h0B});
    peek(2'd2, w); check("R2 ready low next cycle", w[0], 0);
    repeat (P - 1) @(posedge clk);
    @(negedge clk); peek(2'd2, w); check("R2 ready low before end", w[0], 0);
    @(posedge clk); @(negedge clk); peek(2'd2, w); check("R2 ready high at end", w[0], 1);
    exp_bits[2] = 1;
    get_bits("R4 set bit2");
    cmd(8'h0C, 16'd2); exp_bits[2] = 0;
    get_bits("R4 clear bit2");
    cmd(8'h0B, 16'd3); exp_bits[3] = 1;
    get_bits("R4 set bit3");
  endtask

  task automatic t_irq();
    wr_reg(2'd1, 32'h1);
    @(negedge clk); check("R6 irq idle enabled", irq, 1);
    wr_reg(2'd0, {8'h5A, 16'd1, 8'h0B});
    check("R6 irq low busy", irq, 0);
    wait_done(); exp_bits[1] = 1;
    check("R6 irq high done", irq, 1);
    wr_reg(2'd1, 32'h0);
    @(negedge clk); check("R6 irq masked", irq, 0);
  endtask

  task automatic t_range();
    cmd(8'h0B, 16'd4);
    cmd(8'h0C, 16'd5);
    cmd(8'h0C, 16'h0101);
    get_bits("R5 out of range");
  endtask

  task automatic t_badkey();
    logic [31:0] w;
    cmd(8'h0B, 16'd2, 8'hA5);
    peek(2'd2, w); check("R3 bad key status", w, 32'h3);
    rd_reg(2'd2, w); check("R8 read returns err", w[1], 1);
    peek(2'd2, w); check("R8 err cleared", w, 32'h1);
    cmd(8'h0E, 16'd2);
    rd_reg(2'd2, w); check("R3 unknown code err", w, 32'h3);
    get_bits("R3 bits unchanged");
  endtask

  task automatic t_get();
    logic [31:0] w;
    get_bits("R7 get arg ignored", 16'hFFFF);
    rd_reg(2'd3, w); check("R7 word1 zero", w, 0);
    rd_reg(2'd3, w); check("R7 word2 zero", w, 0);
    get_bits("R7 restart word0");
  endtask

  task automatic t_busy();
    wr_reg(2'd0, {8'h5A, 16'd2, 8'h0B});
    wr_reg(2'd0, {8'h5A, 16'd1, 8'h0C});
    wait_done(); exp_bits[2] = 1;
    get_bits("R11 busy write ignored");
  endtask

  task automatic t_secure();
    dbg_req = 1; pp_req = 1; cpu_req = 1;
    @(negedge clk); check("R9 open dbg", dbg_grant, 1);
    wr_reg(2'd0, {8'h5A, 16'd0, 8'h0B});
    check("R9 cpu during busy", cpu_grant, 1);
    wait_done(); exp_bits[0] = 1;
    check("R9 dbg denied", dbg_grant, 0);
    check("R9 pp denied", pp_grant, 0);
    check("R9 cpu granted", cpu_grant, 1);
    cmd(8'h0C, 16'd0);
    get_bits("R10 sw clear bit0 ignored");
    @(negedge clk); full_erase = 1; @(negedge clk); full_erase = 0;
    get_bits("R10 erase without pin");
    @(negedge clk); erase_pin = 1; full_erase = 1; @(negedge clk); full_erase = 0; erase_pin = 0;
    exp_bits = 0;
    get_bits("R10 erase with pin");
    check("R10 dbg restored", dbg_grant, 1);
    check("R10 pp restored", pp_grant, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_timing();
    t_irq();
    t_range();
    t_badkey();
    t_get();
    t_busy();
    t_secure();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule